// File: doc/BRIEF.md
# Inactivity-Driven Power State Controller

This block tracks how long the system has been idle and tells management software when to move it into a deeper low-power state. It holds four states: full power (ON), doze, stand-by and suspend. Each state deeper than ON saves more power. Three inactivity timers guard the way down, with short, medium and long timeouts. The timer belonging to the current state counts prescaled ticks. When it expires, the block raises a management interrupt request. Software then writes the next state into the state register. Any real system activity seen outside ON also raises the request, so that software can return the system to full power.

Short maintenance bursts are filtered while the system is dozing or in stand-by. Such a house-keeping event starts a dedicated timer and does not wake the system at once. It counts as real activity only if the event is still present when that timer runs out. A separate peripheral timer reports peripheral idleness on its own.

In every state, a pulse-width modulated suspend output throttles performance with an on-count and a period chosen for that state. A mask chosen for that state drives the board power-plane enables.

Top module: `pwr_state_ctrl`

## Requirements
- R1: After reset the state is ON (0), the request output is low, all cause bits are 0, the peripheral-idle flag is low, the modulation output is high and every plane enable is 1.
- R2: A write to address 0 sets the state to wdata[1:0] (ON=0, DOZE=1, STANDBY=2, SUSPEND=3) at that edge. The state write also reloads all inactivity timers, clears the house-keeping timer and restarts the prescaler.
- R3: Timeouts live at addresses 2 (doze), 3 (stand-by) and 4 (suspend). In state s (0..2), only the timer at address 2+s counts. With a timeout of T and a tick every cycle, cause bit s and the request rise T edges after the reload. The timer fires once per reload. A timeout of 0 never fires.
- R4: A system activity strobe reloads all three inactivity timers, which postpones expiry.
- R5: Real activity in any state other than ON sets cause bit 3 (wake) and the request. Real activity is a system strobe, or a house-keeping event outside doze and stand-by. Real activity in ON sets no cause bit.
- R6: In doze or stand-by, a house-keeping event starts the house-keeping timer (timeout at address 5) and does not wake the system. The event counts as real activity only if it is still high at the edge where that timer expires.
- R7: The peripheral timer (timeout at address 6) counts in every state and is reloaded by the peripheral strobe. On expiry it sets cause bit 4 and the request, and raises the peripheral-idle flag. The next peripheral strobe lowers that flag.
- R8: The request, once raised, stays high until an acknowledge. A new cause in the same cycle wins over the acknowledge.
- R9: Writing to address 1 clears each cause bit whose wdata bit is 1.
- R10: For state s, address 8+s holds the on-count in wdata[7:0] and the period in wdata[15:8]. Counting k edges from the state write, the modulation output is high when (k mod period) < on-count, and it is always high when the period is 0.
- R11: Address 12+s holds the plane mask for state s. The plane enables always equal the mask of the current state.
- R12: Address 7 holds a prescale value p. Timers then step every p+1 cycles, so a timeout T expires (p+1)*T edges after a state write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sys_act_i | input | 1 | System activity strobe |
| hk_act_i | input | 1 | House-keeping activity level |
| per_act_i | input | 1 | Peripheral activity strobe |
| cfg_we_i | input | 1 | Register write enable |
| cfg_addr_i | input | 4 | Register address |
| cfg_wdata_i | input | 16 | Register write data |
| smi_ack_i | input | 1 | Request acknowledge |
| state_o | output | 2 | Current power state |
| smi_o | output | 1 | Management interrupt request |
| cause_o | output | 5 | Cause bits: doze, stand-by, suspend, wake, peripheral |
| per_idle_o | output | 1 | Peripheral idle flag |
| susp_mod_o | output | 1 | Suspend modulation output |
| plane_en_o | output | 4 | Power-plane enables |

## Verification
The bench sweeps timeouts over every inactivity state and checks the exact expiry edge. It then waits past that edge to confirm that no second request follows, which catches a timer that reloads itself or is off by one. For house-keeping it drives a burst shorter than the filter window and then a held event: a design that wakes on the burst, or never wakes on the held event, fails. It also drives the same strobes in ON and in suspend to confirm that only suspend produces a wake cause. It sweeps modulation settings for on-counts of zero, equal to the period and above it, and for a zero period. It repeats one expiry with a prescale value, which exposes a tick stride that is wrong by one.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  typedef enum logic [1:0] {ST_ON, ST_DOZE, ST_STBY, ST_SUSP} pstate_e;

  localparam int A_STATE = 0;
  localparam int A_CLR   = 1;
  localparam int A_TO    = 2;   // 2..6: doze, stby, susp, hk, per
  localparam int A_PRE   = 7;
  localparam int A_PWM   = 8;   // 8..11
  localparam int A_PLANE = 12;  // 12..15

  localparam int NCAUSE  = 5;
  localparam int C_WAKE  = 3;
  localparam int C_PER   = 4;
  localparam int NTO     = 5;
  localparam int TO_HK   = 3;
  localparam int TO_PER  = 4;
endpackage

// File: rtl/pm_down_timer.sv
module pm_down_timer #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         tick_i,
  output logic         exp_o,
  output logic         busy_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (load_i)                  cnt_q <= load_val_i;
    else if (tick_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign exp_o  = tick_i && !load_i && (cnt_q == W'(1));
  assign busy_o = (cnt_q != '0);

  // R3
  cnt_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && !busy_o |=> !busy_o);
  // R3
  exp_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exp_o |=> !busy_o && !exp_o);
endmodule

// File: rtl/pm_pwm.sv
module pm_pwm #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         restart_i,
  input  logic [W-1:0] on_i,
  input  logic [W-1:0] per_i,
  output logic         pwm_o
);
  logic [W-1:0] cnt_q;
  logic         wrap;

  assign wrap = ({1'b0, cnt_q} + 1'b1) >= {1'b0, per_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (restart_i || wrap) cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  assign pwm_o = (per_i == '0) || (cnt_q < on_i);

  // R10
  pwm_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !restart_i && $stable(per_i) && (cnt_q < per_i) |=> cnt_q < per_i);
  // R10
  pwm_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> cnt_q == '0);
endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
  import pwr_pkg::*;
#(
  parameter int TW     = 16,
  parameter int PW     = 8,
  parameter int PRE_W  = 8,
  parameter int NPLANE = 4,
  parameter int AW     = 4,
  parameter int DW     = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sys_act_i,
  input  logic              hk_act_i,
  input  logic              per_act_i,
  input  logic              cfg_we_i,
  input  logic [AW-1:0]     cfg_addr_i,
  input  logic [DW-1:0]     cfg_wdata_i,
  input  logic              smi_ack_i,
  output logic [1:0]        state_o,
  output logic              smi_o,
  output logic [NCAUSE-1:0] cause_o,
  output logic              per_idle_o,
  output logic              susp_mod_o,
  output logic [NPLANE-1:0] plane_en_o
);
  localparam int NST = 4;

  pstate_e           state_q;
  logic [TW-1:0]     to_q    [NTO];
  logic [PRE_W-1:0]  pre_q, pre_cnt_q;
  logic [2*PW-1:0]   pwm_q   [NST];
  logic [NPLANE-1:0] plane_q [NST];
  logic [NCAUSE-1:0] cause_q, cause_set, cause_clr;
  logic              smi_q, per_idle_q;

  logic st_we, clr_we, pre_we, tick, in_hk, real_act, wake;
  logic [NTO-1:0] to_we;
  logic [NST-1:0] pwm_we, plane_we;

  // Write decode
  assign st_we  = cfg_we_i && cfg_addr_i == AW'(A_STATE);
  assign clr_we = cfg_we_i && cfg_addr_i == AW'(A_CLR);
  assign pre_we = cfg_we_i && cfg_addr_i == AW'(A_PRE);
  always_comb begin
    for (int k = 0; k < NTO; k++) to_we[k] = cfg_we_i && cfg_addr_i == AW'(A_TO + k);
    for (int s = 0; s < NST; s++) begin
      pwm_we[s]   = cfg_we_i && cfg_addr_i == AW'(A_PWM + s);
      plane_we[s] = cfg_we_i && cfg_addr_i == AW'(A_PLANE + s);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_ON;
      pre_q   <= '0;
      for (int k = 0; k < NTO; k++) to_q[k] <= '0;
      for (int s = 0; s < NST; s++) begin
        pwm_q[s]   <= {PW'(1), PW'(1)};
        plane_q[s] <= '1;
      end
    end else begin
      if (st_we)  state_q <= pstate_e'(cfg_wdata_i[1:0]);
      if (pre_we) pre_q   <= cfg_wdata_i[PRE_W-1:0];
      for (int k = 0; k < NTO; k++) if (to_we[k]) to_q[k] <= cfg_wdata_i[TW-1:0];
      for (int s = 0; s < NST; s++) begin
        if (pwm_we[s])   pwm_q[s]   <= cfg_wdata_i[2*PW-1:0];
        if (plane_we[s]) plane_q[s] <= cfg_wdata_i[NPLANE-1:0];
      end
    end
  end

  // Prescaler: restarts on state or prescale writes
  assign tick = (pre_cnt_q == pre_q);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        pre_cnt_q <= '0;
    else if (st_we || pre_we || tick)   pre_cnt_q <= '0;
    else                                pre_cnt_q <= pre_cnt_q + 1'b1;
  end

  // House-keeping filter
  logic hk_load, hk_exp, hk_busy, hk_start;
  logic [TW-1:0] hk_val;
  assign in_hk    = (state_q == ST_DOZE) || (state_q == ST_STBY);
  assign hk_start = hk_act_i && in_hk && !hk_busy;
  assign hk_load  = st_we || hk_start || to_we[TO_HK];
  assign hk_val   = st_we ? '0 : (to_we[TO_HK] ? cfg_wdata_i[TW-1:0] : to_q[TO_HK]);

  pm_down_timer #(.W(TW)) i_hk_tmr (
    .clk_i, .rst_ni, .load_i(hk_load), .load_val_i(hk_val),
    .tick_i(tick && in_hk), .exp_o(hk_exp), .busy_o(hk_busy)
  );

  assign real_act = sys_act_i || (hk_act_i && !in_hk) || (hk_exp && hk_act_i);
  assign wake     = real_act && (state_q != ST_ON);

  // Inactivity timers, one per state above suspend
  logic [2:0] inact_exp;
  for (genvar g = 0; g < 3; g++) begin : g_inact
    logic          ld, unused_busy;
    logic [TW-1:0] val;
    assign ld  = st_we || real_act || to_we[g];
    assign val = to_we[g] ? cfg_wdata_i[TW-1:0] : to_q[g];
    pm_down_timer #(.W(TW)) i_tmr (
      .clk_i, .rst_ni, .load_i(ld), .load_val_i(val),
      .tick_i(tick && state_q == pstate_e'(g)), .exp_o(inact_exp[g]), .busy_o(unused_busy)
    );
  end

  // Peripheral idleness
  logic per_exp, per_busy_unused;
  logic [TW-1:0] per_val;
  assign per_val = to_we[TO_PER] ? cfg_wdata_i[TW-1:0] : to_q[TO_PER];
  pm_down_timer #(.W(TW)) i_per_tmr (
    .clk_i, .rst_ni, .load_i(per_act_i || to_we[TO_PER]), .load_val_i(per_val),
    .tick_i(tick), .exp_o(per_exp), .busy_o(per_busy_unused)
  );

  // Cause bits and request
  assign cause_set = {per_exp, wake, inact_exp};
  assign cause_clr = clr_we ? cfg_wdata_i[NCAUSE-1:0] : '0;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q    <= '0;
      smi_q      <= 1'b0;
      per_idle_q <= 1'b0;
    end else begin
      cause_q <= (cause_q & ~cause_clr) | cause_set;
      if (|cause_set)     smi_q <= 1'b1;
      else if (smi_ack_i) smi_q <= 1'b0;
      if (per_exp)        per_idle_q <= 1'b1;
      else if (per_act_i) per_idle_q <= 1'b0;
    end
  end

  pm_pwm #(.W(PW)) i_pwm (
    .clk_i, .rst_ni, .restart_i(st_we),
    .on_i(pwm_q[state_q][PW-1:0]), .per_i(pwm_q[state_q][2*PW-1:PW]),
    .pwm_o(susp_mod_o)
  );

  assign state_o    = state_q;
  assign smi_o      = smi_q;
  assign cause_o    = cause_q;
  assign per_idle_o = per_idle_q;
  assign plane_en_o = plane_q[state_q];

  // R2
  state_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_we |=> state_o == $past(cfg_wdata_i[1:0]));
  // R5
  no_wake_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cause_o[C_WAKE]) |-> $past(state_q) != ST_ON);
  // R8
  smi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smi_o && !smi_ack_i |=> smi_o);
  // R9
  cause_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we && cause_set == '0 |=> (cause_o & $past(cfg_wdata_i[NCAUSE-1:0])) == '0);
  // R7
  per_idle_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_act_i |=> !per_idle_o);
endmodule

// File: tb/test_pwr_state_ctrl.sv
module test_pwr_state_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sys_act = 0, hk_act = 0, per_act = 0, we = 0, ack = 0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [1:0] state;
  logic smi, per_idle, smod;
  logic [4:0] cause;
  logic [3:0] plane;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  pwr_state_ctrl i_pwr_state_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .sys_act_i(sys_act), .hk_act_i(hk_act),
    .per_act_i(per_act), .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
    .smi_ack_i(ack), .state_o(state), .smi_o(smi), .cause_o(cause),
    .per_idle_o(per_idle), .susp_mod_o(smod), .plane_en_o(plane)
  );

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    we = 1; addr = 4'(a); wdata = 16'(d);
    @(negedge clk);
    we = 0;
  endtask

  task automatic pulse_sys();
    sys_act = 1; @(negedge clk); sys_act = 0;
  endtask

  task automatic ack_clr();
    ack = 1; @(negedge clk); ack = 0;
    wr(1, 16'h1F);
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    // R1 reset state
    check("R1 state", state, 0);
    check("R1 smi", smi, 0);
    check("R1 cause", cause, 0);
    check("R1 per_idle", per_idle, 0);
    check("R1 mod", smod, 1);
    check("R1 plane", plane, 15);

    // R2 / R11: state write and per-state plane mask
    for (int s = 0; s < 4; s++) wr(12 + s, (s * 5 + 3) & 15);
    for (int s = 3; s >= 0; s--) begin
      wr(0, s);
      check("R2 state", state, s);
      check("R11 plane", plane, (s * 5 + 3) & 15);
    end

    // R3 expiry sweep, R8 hold, R9 clear
    for (int s = 0; s < 3; s++) begin
      for (int ti = 0; ti < 3; ti++) begin
        int t;
        t = (ti == 0) ? 1 : (ti == 1 ? 2 : 5);
        wr(2 + s, t);
        wr(0, s);
        if (t > 1) begin
          step(t - 1);
          check("R3 before expiry", smi, 0);
        end
        step(1);
        check("R3 smi at expiry", smi, 1);
        check("R3 cause", cause, 1 << s);
        step(4);
        check("R8 smi held", smi, 1);
        ack_clr();
        check("R8 smi acked", smi, 0);
        check("R9 cause cleared", cause, 0);
        step(4);
        check("R3 fires once", smi, 0);
      end
      wr(2 + s, 0);
    end

    // R4 activity reloads; R5 no wake in ON
    wr(2, 6);
    wr(0, 0);
    step(4);
    pulse_sys();
    step(5);
    check("R4 postponed", smi, 0);
    step(1);
    check("R4 expiry after reload", smi, 1);
    check("R5 no wake in ON", cause, 1);
    ack_clr();
    wr(2, 0);
    hk_act = 1; step(1); hk_act = 0;
    check("R5 hk in ON no cause", cause, 0);

    // R5 wake from stand-by and suspend
    wr(0, 2);
    pulse_sys();
    check("R5 wake smi", smi, 1);
    check("R5 wake cause", cause, 8);
    check("R5 state kept", state, 2);
    ack_clr();
    wr(0, 3);
    hk_act = 1; step(1); hk_act = 0;
    check("R5 hk in suspend wakes", cause, 8);
    ack_clr();

    // R6 house-keeping filter
    wr(5, 4);
    for (int s = 1; s <= 2; s++) begin
      wr(0, s);
      hk_act = 1; step(2); hk_act = 0;
      step(6);
      check("R6 burst no smi", smi, 0);
      check("R6 burst no cause", cause, 0);
      hk_act = 1;
      step(4);
      check("R6 held before expiry", smi, 0);
      step(1);
      check("R6 held wakes", smi, 1);
      check("R6 wake cause", cause, 8);
      hk_act = 0;
      ack_clr();
    end
    wr(5, 0);

    // R7 peripheral timer
    wr(0, 0);
    wr(6, 3);
    step(2);
    check("R7 not idle yet", per_idle, 0);
    step(1);
    check("R7 idle", per_idle, 1);
    check("R7 cause", cause, 16);
    check("R7 smi", smi, 1);
    per_act = 1; step(1); per_act = 0;
    check("R7 idle cleared", per_idle, 0);
    wr(6, 0);
    ack_clr();

    // R12 prescaler
    wr(7, 2);
    wr(2, 2);
    wr(0, 0);
    step(5);
    check("R12 before scaled expiry", smi, 0);
    step(1);
    check("R12 scaled expiry", smi, 1);
    ack_clr();
    wr(7, 0);
    wr(2, 0);

    // R10 modulation sweep
    for (int c = 0; c < 6; c++) begin
      int on, per, s;
      case (c)
        0: begin on = 1; per = 3; end
        1: begin on = 2; per = 5; end
        2: begin on = 4; per = 4; end
        3: begin on = 0; per = 3; end
        4: begin on = 3; per = 1; end
        default: begin on = 5; per = 0; end
      endcase
      s = c % 4;
      wr(8 + s, (per << 8) | on);
      wr(0, s);
      for (int k = 0; k < 2 * per + 2; k++) begin
        int exp;
        exp = (per == 0) ? 1 : (((k % per) < on) ? 1 : 0);
        check("R10 mod", smod, exp);
        step(1);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule